// File: doc/BRIEF.md
# Autovectored Priority Level Arbiter

This block stands between a set of ranked interrupt request lines and a processor core. Each request line has its own priority level. Line 0 ranks highest, and the ranking falls as the line index rises. The block holds a current interrupt priority level (IPL) register that acts as a threshold. Only lines whose index is strictly below the IPL can interrupt.

In every cycle the block picks the highest-ranked request that the threshold lets through. When it finds one, it raises the interrupt output and presents an autovector: a fixed base plus the winning line index. When the core accepts the interrupt, the IPL register takes the serviced index in the same clock edge. That edge also copies the old IPL into a saved-level register. The new threshold blocks the serviced line and every line below it, so a second acknowledge of the same line cannot happen. Higher-ranked lines can still preempt, which gives nesting in hardware.

When the handler finishes, software writes the saved value back through the level write port. That write restores the previous threshold.

Top module: `prio_lvl_arb`

## Requirements
- R1: While reset is high and on the first cycle after it, the IPL register reads 0, the saved level reads 0, and the interrupt output is low.
- R2: Request line i is eligible only when the IPL is greater than i. An IPL of 0 masks every line and an IPL of NUM_LEVELS (8) enables all of them. The interrupt output is high exactly when at least one eligible line is asserted.
- R3: When several eligible lines are asserted, the winner is the one with the smallest index.
- R4: The vector output equals VEC_BASE (24) plus the winning index while the interrupt output is high, and 0 while it is low.
- R5: An acknowledge in a cycle where the interrupt output is high loads the winning index into the IPL at the next edge. From that cycle onward the same unchanged request no longer raises the interrupt output.
- R6: An accepted acknowledge copies the IPL value from before the edge into the saved-level output.
- R7: A write with no accepted acknowledge loads the written value into the IPL. Any value above NUM_LEVELS is loaded as NUM_LEVELS.
- R8: When an accepted acknowledge and a write arrive in the same cycle, the acknowledge wins and the written value is discarded.
- R9: An acknowledge while the interrupt output is low has no effect: the IPL and the saved level keep their values.
- R10: With no write and no accepted acknowledge, the IPL and the saved level hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_LEVELS | Request lines; index 0 ranks highest |
| ipl_wr_en | input | 1 | Load the IPL from ipl_wr_data (set or restore) |
| ipl_wr_data | input | LVL_W | Level to load; values above NUM_LEVELS clamp |
| int_ack | input | 1 | Core accepts the presented interrupt |
| int_req | output | 1 | Interrupt to the core |
| int_vec | output | VEC_W | Autovector: VEC_BASE plus winning index |
| ipl_cur | output | LVL_W | Current IPL register |
| ipl_saved | output | LVL_W | IPL captured at the last accepted acknowledge |

## Verification
The bench builds the arbiter with its default parameters: eight levels, a vector base of 24, and 8-bit vectors, so the IPL is 4 bits wide. This makes the clamp reachable, because write values 9 to 15 fit in the port and must saturate to 8. Random request patterns, mixed with acknowledge and write traffic, move the IPL across its whole range of 0 to 8. That range covers the all-masked case, the all-enabled case, nested raises, and restores. Directed cases cover acknowledge/write collisions and acknowledges that arrive with no interrupt pending.

// File: rtl/prio_lvl_arb_pkg.sv
package prio_lvl_arb_pkg;

    localparam int DEF_LEVELS   = 8;
    localparam int DEF_VEC_BASE = 24;
    localparam int DEF_VEC_W    = 8;

    typedef enum logic [1:0] {
        IPL_HOLD  = 2'd0,
        IPL_RAISE = 2'd1,
        IPL_LOAD  = 2'd2
    } ipl_op_e;

    // acknowledge outranks a software write in the same cycle
    function automatic ipl_op_e pick_op(input logic ack_taken, input logic wr_en);
        if (ack_taken)
            return IPL_RAISE;
        else if (wr_en)
            return IPL_LOAD;
        else
            return IPL_HOLD;
    endfunction

endpackage

// File: rtl/prio_lvl_gate.sv
module prio_lvl_gate #(
    parameter int NUM_LEVELS = 8,
    parameter int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
    input  logic [NUM_LEVELS-1:0] req,
    input  logic [LVL_W-1:0]      ipl,
    output logic [NUM_LEVELS-1:0] eligible
);

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        localparam logic [LVL_W-1:0] LVL_IDX = LVL_W'(g);
        assign eligible[g] = req[g] && (ipl > LVL_IDX);
    end

endmodule

// File: rtl/prio_lvl_pick.sv
module prio_lvl_pick #(
    parameter int NUM_LEVELS = 8,
    parameter int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
    input  logic [NUM_LEVELS-1:0] eligible,
    output logic                  hit,
    output logic [LVL_W-1:0]      idx
);

    always_comb begin
        idx = '0;
        for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
            if (eligible[i])
                idx = LVL_W'(i);
        end
    end

    assign hit = |eligible;

endmodule

// File: rtl/prio_lvl_ipl.sv
module prio_lvl_ipl
    import prio_lvl_arb_pkg::*;
#(
    parameter int NUM_LEVELS = 8,
    parameter int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack_taken,
    input  logic [LVL_W-1:0] win_idx,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_data,
    output logic [LVL_W-1:0] ipl,
    output logic [LVL_W-1:0] saved
);

    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(NUM_LEVELS);

    ipl_op_e          op;
    logic [LVL_W-1:0] wr_lim;

    assign op     = pick_op(ack_taken, wr_en);
    assign wr_lim = (wr_data > LVL_MAX) ? LVL_MAX : wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ipl   <= '0;
            saved <= '0;
        end else begin
            case (op)
                IPL_RAISE: begin
                    saved <= ipl;
                    ipl   <= win_idx;
                end
                IPL_LOAD:  ipl <= wr_lim;
                default:   ipl <= ipl;
            endcase
        end
    end

endmodule

// File: rtl/prio_lvl_arb.sv
module prio_lvl_arb
    import prio_lvl_arb_pkg::*;
#(
    parameter int NUM_LEVELS = DEF_LEVELS,
    parameter int VEC_BASE   = DEF_VEC_BASE,
    parameter int VEC_W      = DEF_VEC_W,
    parameter int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LEVELS-1:0] irq_req,
    input  logic                  ipl_wr_en,
    input  logic [LVL_W-1:0]      ipl_wr_data,
    input  logic                  int_ack,
    output logic                  int_req,
    output logic [VEC_W-1:0]      int_vec,
    output logic [LVL_W-1:0]      ipl_cur,
    output logic [LVL_W-1:0]      ipl_saved
);

    logic [NUM_LEVELS-1:0] eligible;
    logic                  hit;
    logic [LVL_W-1:0]      win_idx;

    prio_lvl_gate #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) gate_i (
        .req      (irq_req),
        .ipl      (ipl_cur),
        .eligible (eligible)
    );

    prio_lvl_pick #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) pick_i (
        .eligible (eligible),
        .hit      (hit),
        .idx      (win_idx)
    );

    prio_lvl_ipl #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) ipl_i (
        .clk       (clk),
        .rst       (rst),
        .ack_taken (int_ack && hit),
        .win_idx   (win_idx),
        .wr_en     (ipl_wr_en),
        .wr_data   (ipl_wr_data),
        .ipl       (ipl_cur),
        .saved     (ipl_saved)
    );

    assign int_req = hit;
    assign int_vec = hit ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx)) : '0;

endmodule

// File: rtl/prio_lvl_arb_chk.sv
module prio_lvl_arb_chk #(
    parameter int NUM_LEVELS = 8,
    parameter int VEC_BASE   = 24,
    parameter int VEC_W      = 8,
    parameter int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_LEVELS-1:0] irq_req,
    input logic                  ipl_wr_en,
    input logic [LVL_W-1:0]      ipl_wr_data,
    input logic                  int_ack,
    input logic                  int_req,
    input logic [VEC_W-1:0]      int_vec,
    input logic [LVL_W-1:0]      ipl_cur,
    input logic [LVL_W-1:0]      ipl_saved
);

    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(NUM_LEVELS);

    logic [VEC_W-1:0]      lvl_of_vec;
    logic [NUM_LEVELS-1:0] above_mask;
    logic [LVL_W-1:0]      wr_lim;

    assign lvl_of_vec = int_vec - VEC_W'(VEC_BASE);
    assign wr_lim     = (ipl_wr_data > LVL_MAX) ? LVL_MAX : ipl_wr_data;

    always_comb begin
        for (int i = 0; i < NUM_LEVELS; i++)
            above_mask[i] = (VEC_W'(i) < lvl_of_vec);
    end

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (ipl_cur == '0 && ipl_saved == '0 && !int_req));

    // R2
    a_r2_below_threshold: assert property (@(posedge clk) disable iff (rst)
        int_req |-> (lvl_of_vec < VEC_W'(ipl_cur) && irq_req[lvl_of_vec[LVL_W-1:0]]));

    // R2
    a_r2_idle_when_quiet: assert property (@(posedge clk) disable iff (rst)
        (irq_req == '0 || ipl_cur == '0) |-> !int_req);

    // R3
    a_r3_highest_wins: assert property (@(posedge clk) disable iff (rst)
        int_req |-> ((irq_req & above_mask) == '0));

    // R4
    a_r4_vec_zero_idle: assert property (@(posedge clk) disable iff (rst)
        !int_req |-> (int_vec == '0));

    // R5, R8
    a_r5_raise_on_ack: assert property (@(posedge clk) disable iff (rst)
        (int_ack && int_req) |=> (VEC_W'(ipl_cur) == $past(lvl_of_vec)));

    // R6
    a_r6_save_prev: assert property (@(posedge clk) disable iff (rst)
        (int_ack && int_req) |=> (ipl_saved == $past(ipl_cur)));

    // R7
    a_r7_write_clamped: assert property (@(posedge clk) disable iff (rst)
        (ipl_wr_en && !(int_ack && int_req)) |=> (ipl_cur == $past(wr_lim)));

    // R9, R10
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!ipl_wr_en && !(int_ack && int_req)) |=> ($stable(ipl_cur) && $stable(ipl_saved)));

endmodule

bind prio_lvl_arb prio_lvl_arb_chk #(
    .NUM_LEVELS (NUM_LEVELS),
    .VEC_BASE   (VEC_BASE),
    .VEC_W      (VEC_W),
    .LVL_W      (LVL_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .irq_req     (irq_req),
    .ipl_wr_en   (ipl_wr_en),
    .ipl_wr_data (ipl_wr_data),
    .int_ack     (int_ack),
    .int_req     (int_req),
    .int_vec     (int_vec),
    .ipl_cur     (ipl_cur),
    .ipl_saved   (ipl_saved)
);

// File: tb/prio_lvl_arb_tb_top.sv
module prio_lvl_arb_tb_top;

    localparam int N     = 8;
    localparam int BASE  = 24;
    localparam int VW    = 8;
    localparam int LW    = $clog2(N + 1);
    localparam int CLK_P = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  irq_req;
    logic          ipl_wr_en;
    logic [LW-1:0] ipl_wr_data;
    logic          int_ack;
    logic          int_req;
    logic [VW-1:0] int_vec;
    logic [LW-1:0] ipl_cur;
    logic [LW-1:0] ipl_saved;

    int checks   = 0;
    int failures = 0;
    int m_ipl    = 0;
    int m_saved  = 0;
    bit done     = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    prio_lvl_arb #(.NUM_LEVELS(N), .VEC_BASE(BASE), .VEC_W(VW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .irq_req     (irq_req),
        .ipl_wr_en   (ipl_wr_en),
        .ipl_wr_data (ipl_wr_data),
        .int_ack     (int_ack),
        .int_req     (int_req),
        .int_vec     (int_vec),
        .ipl_cur     (ipl_cur),
        .ipl_saved   (ipl_saved)
    );

    function automatic int exp_idx(input logic [N-1:0] r, input int ipl);
        for (int i = 0; i < N; i++)
            if (r[i] && i < ipl) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at falling edge, check combinational outputs and state, then advance
    task automatic step(input logic [N-1:0] r, input logic ack, input logic wr,
                        input int data, input string tag);
        int w;
        @(negedge clk);
        irq_req     = r;
        int_ack     = ack;
        ipl_wr_en   = wr;
        ipl_wr_data = LW'(data);
        #1;
        w = exp_idx(r, m_ipl);
        chk({tag, " R2 int_req"}, int'(int_req), (w >= 0) ? 1 : 0);
        chk({tag, " R3/R4 int_vec"}, int'(int_vec), (w >= 0) ? BASE + w : 0);
        chk({tag, " R10 ipl_cur"}, int'(ipl_cur), m_ipl);
        chk({tag, " R6 ipl_saved"}, int'(ipl_saved), m_saved);
        @(posedge clk);
        if (ack && w >= 0) begin
            m_saved = m_ipl;
            m_ipl   = w;
        end else if (wr) begin
            m_ipl = (data > N) ? N : data;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7301));
        rst = 1'b1; irq_req = '0; int_ack = 0; ipl_wr_en = 0; ipl_wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        irq_req = 8'hFF;
        #1;
        chk("R1 ipl in reset", int'(ipl_cur), 0);
        chk("R1 int_req in reset", int'(int_req), 0);
        rst = 1'b0;
        @(posedge clk);
        // R1: masked by IPL 0 after reset
        step(8'hFF, 1'b1, 1'b0, 0, "R1 R9 post-reset");
        // R7: open all levels
        step(8'h00, 1'b0, 1'b1, 8, "R7 set 8");
        // R3: two requests, lower index wins -> level 5 vec 29
        step(8'hA0, 1'b1, 1'b0, 0, "R5 ack lvl5");
        // R5: same request now blocked
        step(8'hA0, 1'b1, 1'b0, 0, "R5 no dup");
        // nesting: level 2 preempts
        step(8'hA4, 1'b1, 1'b0, 0, "R5 nest lvl2");
        step(8'hA4, 1'b0, 1'b0, 0, "R10 hold");
        // R7 restore saved value 5
        step(8'h00, 1'b0, 1'b1, 5, "R7 restore");
        // R7 clamp 15 -> 8
        step(8'h00, 1'b0, 1'b1, 15, "R7 clamp");
        step(8'h80, 1'b0, 1'b0, 0, "R2 lvl7 open");
        // R8: ack and write together
        step(8'h80, 1'b1, 1'b1, 3, "R8 ack beats write");
        step(8'h00, 1'b0, 1'b0, 0, "R8 after");
        // R9: ack with nothing pending, write level 0 after
        step(8'h00, 1'b1, 1'b0, 0, "R9 idle ack");
        step(8'h01, 1'b0, 1'b1, 0, "R7 mask all");
        step(8'h01, 1'b1, 1'b0, 0, "R2 ipl0 masked");
        step(8'h00, 1'b0, 1'b0, 0, "R9 check");

        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] r;
            r = N'($urandom);
            if ($urandom_range(0, 3) == 0) r = '0;
            step(r, ($urandom_range(0, 2) == 0), ($urandom_range(0, 5) == 0),
                 $urandom_range(0, 15), "rand");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule